// File: doc/BRIEF.md
# Horizontal packed double-precision adder

The block accepts two 128-bit operands, each carrying two IEEE 754 binary64 values, and forms the pairwise sum inside each operand. The lower half of the result is the sum of the two values held in the first operand. The upper half is the sum of the two values held in the second operand. Lanes are never combined across the two operands. Each sum is correctly rounded in the requested rounding mode. The exception flags raised by both sums are merged into one 5-bit status word.

One combinational binary64 adder is shared between the two lanes. A four-state controller uses it twice. The states are IDLE, LOW, HIGH and RESP, and they follow one another as below:

- IDLE to LOW (accept): an aligned request is accepted.
- LOW to HIGH (first sum): the lower-lane sum is latched.
- HIGH to RESP (second sum): the upper-lane sum is written together with the held lower sum.
- RESP to IDLE (retire): the response has been presented.

A request whose second operand is flagged as coming from memory, and whose low address nibble is not zero, takes the IDLE to RESP (reject) transition. It reports an alignment fault and leaves the result register untouched.

Because the first operand also serves as the destination, the visible result register changes only once, after both lane sums exist.

Top module: `hpd_adder`

## Requirements
- R1: `res[63:0]` is the correctly rounded binary64 sum of `op_a[63:0]` and `op_a[127:64]`.
- R2: `res[127:64]` is the correctly rounded binary64 sum of `op_b[63:0]` and `op_b[127:64]`.
- R3: `rmode` selects the rounding as follows: 0 nearest-even, 1 toward minus infinity, 2 toward plus infinity, 3 toward zero.
- R4: `flags` bits are: bit0 invalid, bit1 denormal operand, bit2 overflow, bit3 underflow, bit4 precision. The word reported is the bitwise OR of the two lanes' flags.
- R5: When the exponent overflows, overflow and precision are set. The result is signed infinity when the mode rounds away from zero. Otherwise it is the signed largest finite value. Toward zero always gives the largest finite value.
- R6: Infinities of opposite sign, or any signalling NaN input, give 0xFFF8000000000000 with invalid set. A quiet NaN input propagates unchanged with no flag. The lower-addressed value of the pair is chosen first.
- R7: An exact zero from opposite-signed inputs is +0, except in round toward minus infinity, where it is -0.
- R8: A subnormal input sets the denormal flag. A sum that lands in the subnormal range is exact and gives the bit-exact subnormal or smallest normal with underflow clear. Underflow is set only for a tiny inexact result.
- R9: A request with `src_mem`=1 and `addr_lo`≠0 raises `align_fault` in the cycle after acceptance. `res` stays at its prior value and `flags` reads 0. With `src_mem`=0 the address nibble is ignored.
- R10: `in_ready` is high only in IDLE. An accepted aligned request shows `out_valid` for one cycle, three cycles after acceptance. `res` never changes except on entry to that cycle.
- R11: After reset `in_ready`=1, `out_valid`=0, and `res`, `flags` and `align_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Controller idle, request is taken this cycle |
| op_a | input | 128 | First operand; its two values sum into the lower lane |
| op_b | input | 128 | Second operand; its two values sum into the upper lane |
| src_mem | input | 1 | Second operand comes from memory |
| addr_lo | input | 4 | Low nibble of the second operand's address |
| rmode | input | 2 | Rounding mode (R3 encoding) |
| out_valid | output | 1 | One-cycle response strobe |
| res | output | 128 | Result register |
| flags | output | 5 | Merged exception flags (R4 layout) |
| align_fault | output | 1 | Misaligned memory source reported |

## Verification
Each accepted aligned request produces its response in the third cycle after the accepting edge, once LOW and HIGH have each taken one cycle. A rejected request responds in the very next cycle. The bench drives on falling edges and then counts falling edges until `out_valid` appears. It checks that count against those figures, and only then samples `res`, `flags` and `align_fault`. While the count is below three, it also confirms that `res` still shows the previous result, so that the destination is seen to change only after both sums.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = FP_W - EXP_W - 1;
    localparam int MANT_W = FRAC_W + 1;
    localparam int GRS_W  = 3;
    localparam int WORK_W = MANT_W + GRS_W;
    localparam int DSH_W  = $clog2(WORK_W + 1);
    localparam logic [FP_W-1:0] QNAN_DEF = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_DOWN = 2'd1,
        RM_UP   = 2'd2,
        RM_ZERO = 2'd3
    } rmode_e;

    typedef struct packed {
        logic prec;
        logic unfl;
        logic ovfl;
        logic deno;
        logic inval;
    } fp_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_RESP
    } hpd_state_e;
endpackage

// File: rtl/hpd_fadd.sv
module hpd_fadd
    import hpd_pkg::*;
(
    input  logic [FP_W-1:0] x,
    input  logic [FP_W-1:0] y,
    input  rmode_e          rm,
    output logic [FP_W-1:0] sum,
    output fp_flags_t       flg
);
    logic               sx, sy, sl, ss, sub, sgn, to_inf, inc, g, st, inexact;
    logic [EXP_W-1:0]   ex, ey, xl, xs, d, lim, shamt;
    logic [FRAC_W-1:0]  fx, fy;
    logic [MANT_W-1:0]  ml, ms;
    logic [DSH_W-1:0]   dd, lz;
    logic [WORK_W-1:0]  sm_w, sm_sh, sm_al, nrm;
    logic [WORK_W:0]    raw;
    logic [EXP_W:0]     e, ef;
    logic [MANT_W:0]    mr;
    logic               x_nan, y_nan, x_snan, y_snan, x_inf, y_inf, swap;

    assign {sx, ex, fx} = x;
    assign {sy, ey, fy} = y;
    assign x_nan  = (&ex) && (|fx);
    assign y_nan  = (&ey) && (|fy);
    assign x_snan = x_nan && !fx[FRAC_W-1];
    assign y_snan = y_nan && !fy[FRAC_W-1];
    assign x_inf  = (&ex) && !(|fx);
    assign y_inf  = (&ey) && !(|fy);
    assign swap   = y[FP_W-2:0] > x[FP_W-2:0];

    always_comb begin
        sl  = swap ? sy : sx;
        ss  = swap ? sx : sy;
        ml  = swap ? {|ey, fy} : {|ex, fx};
        ms  = swap ? {|ex, fx} : {|ey, fy};
        xl  = swap ? ((ey == '0) ? EXP_W'(1) : ey) : ((ex == '0) ? EXP_W'(1) : ex);
        xs  = swap ? ((ex == '0) ? EXP_W'(1) : ex) : ((ey == '0) ? EXP_W'(1) : ey);
        sub = sl ^ ss;
        d   = xl - xs;
        dd  = (d > EXP_W'(WORK_W)) ? DSH_W'(WORK_W) : d[DSH_W-1:0];
        // align the smaller magnitude, folding every lost bit into the sticky position
        sm_w  = {ms, {GRS_W{1'b0}}};
        sm_sh = sm_w >> dd;
        sm_al = {sm_sh[WORK_W-1:1], sm_sh[0] | (|(sm_w & ~({WORK_W{1'b1}} << dd)))};
        raw   = sub ? ({1'b0, ml, {GRS_W{1'b0}}} - {1'b0, sm_al})
                    : ({1'b0, ml, {GRS_W{1'b0}}} + {1'b0, sm_al});
        lz = DSH_W'(WORK_W);
        for (int i = 0; i < WORK_W; i++)
            if (raw[i]) lz = DSH_W'(WORK_W - 1 - i);
        lim   = xl - EXP_W'(1);
        shamt = ({{(EXP_W-DSH_W){1'b0}}, lz} < lim) ? {{(EXP_W-DSH_W){1'b0}}, lz} : lim;
        if (raw[WORK_W]) begin
            nrm = {raw[WORK_W:2], raw[1] | raw[0]};
            e   = {1'b0, xl} + (EXP_W+1)'(1);
        end else begin
            nrm = raw[WORK_W-1:0] << shamt;
            e   = {1'b0, xl} - {1'b0, shamt};
        end
        sgn     = (raw == '0 && sub) ? (rm == RM_DOWN) : sl;
        g       = nrm[GRS_W-1];
        st      = |nrm[GRS_W-2:0];
        inexact = g | st;
        unique case (rm)
            RM_NEAR: inc = g & (st | nrm[GRS_W]);
            RM_UP:   inc = inexact & !sgn;
            RM_DOWN: inc = inexact & sgn;
            default: inc = 1'b0;
        endcase
        to_inf = (rm == RM_NEAR) || (rm == RM_UP && !sgn) || (rm == RM_DOWN && sgn);
        mr = {1'b0, nrm[WORK_W-1:GRS_W]} + (MANT_W+1)'(inc);
        ef = mr[MANT_W] ? e + (EXP_W+1)'(1) : (mr[MANT_W-1] ? e : '0);
        flg       = '0;
        flg.deno  = ((ex == '0 && fx != '0) || (ey == '0 && fy != '0)) && !x_nan && !y_nan;
        if (x_nan || y_nan) begin
            flg.inval = x_snan | y_snan;
            sum       = (x_snan | y_snan) ? QNAN_DEF : (x_nan ? x : y);
        end else if (x_inf || y_inf) begin
            flg.inval = x_inf && y_inf && (sx != sy);
            sum       = flg.inval ? QNAN_DEF : (x_inf ? x : y);
        end else if (raw == '0) begin
            sum = {sgn, {(FP_W-1){1'b0}}};
        end else if (ef >= {1'b0, {EXP_W{1'b1}}}) begin
            flg.ovfl = 1'b1;
            flg.prec = 1'b1;
            sum = to_inf ? {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                         : {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else begin
            flg.prec = inexact;
            flg.unfl = inexact && !nrm[WORK_W-1];
            sum = {sgn, ef[EXP_W-1:0], mr[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/hpd_adder.sv
module hpd_adder
    import hpd_pkg::*;
#(
    parameter int ALIGN_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2*FP_W-1:0]    op_a,
    input  logic [2*FP_W-1:0]    op_b,
    input  logic                 src_mem,
    input  logic [ALIGN_W-1:0]   addr_lo,
    input  logic [1:0]           rmode,
    output logic                 out_valid,
    output logic [2*FP_W-1:0]    res,
    output logic [4:0]           flags,
    output logic                 align_fault
);
    hpd_state_e        st_q, st_d;
    logic [2*FP_W-1:0] a_q, b_q, res_q;
    logic [FP_W-1:0]   lo_q, add_x, add_y, add_sum;
    rmode_e            rm_q;
    fp_flags_t         lo_flg_q, flg_q, add_flg;
    logic              flt_q, misaligned;

    assign misaligned = src_mem && (addr_lo != '0);
    assign add_x = (st_q == ST_HIGH) ? b_q[FP_W-1:0]      : a_q[FP_W-1:0];
    assign add_y = (st_q == ST_HIGH) ? b_q[2*FP_W-1:FP_W] : a_q[2*FP_W-1:FP_W];

    hpd_fadd u_fadd (
        .x   (add_x),
        .y   (add_y),
        .rm  (rm_q),
        .sum (add_sum),
        .flg (add_flg)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (in_valid) st_d = misaligned ? ST_RESP : ST_LOW;
            ST_LOW:  st_d = ST_HIGH;
            ST_HIGH: st_d = ST_RESP;
            ST_RESP: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            rm_q     <= RM_NEAR;
            lo_q     <= '0;
            lo_flg_q <= '0;
            res_q    <= '0;
            flg_q    <= '0;
            flt_q    <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (in_valid) begin
                    a_q  <= op_a;
                    b_q  <= op_b;
                    rm_q <= rmode_e'(rmode);
                    if (misaligned) begin
                        flg_q <= '0;
                        flt_q <= 1'b1;
                    end
                end
                ST_LOW: begin
                    lo_q     <= add_sum;
                    lo_flg_q <= add_flg;
                end
                ST_HIGH: begin
                    res_q <= {add_sum, lo_q};
                    flg_q <= lo_flg_q | add_flg;
                    flt_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        in_ready    = (st_q == ST_IDLE);
        out_valid   = (st_q == ST_RESP);
        res         = res_q;
        flags       = flg_q;
        align_fault = flt_q;
    end
endmodule

// File: rtl/hpd_adder_chk.sv
module hpd_adder_chk #(
    parameter int ALIGN_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               src_mem,
    input logic [ALIGN_W-1:0] addr_lo,
    input logic               out_valid,
    input logic [127:0]       res,
    input logic [4:0]         flags,
    input logic               align_fault
);
    p_fault_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && src_mem && addr_lo != '0) |=> (out_valid && align_fault));

    p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && align_fault) |-> ($stable(res) && flags == 5'd0));

    p_good_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !(src_mem && addr_lo != '0)) |-> ##3 (out_valid && !align_fault));

    p_res_only_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res) |-> (out_valid && !align_fault));

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_resp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (!out_valid && in_ready));
endmodule

bind hpd_adder hpd_adder_chk #(.ALIGN_W(ALIGN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .src_mem     (src_mem),
    .addr_lo     (addr_lo),
    .out_valid   (out_valid),
    .res         (res),
    .flags       (flags),
    .align_fault (align_fault)
);

// File: tb/hpd_adder_tb.sv
`timescale 1ns/1ps
module hpd_adder_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] op_a = '0, op_b = '0;
    logic         src_mem = 1'b0;
    logic [3:0]   addr_lo = '0;
    logic [1:0]   rmode = 2'd0;
    logic         out_valid;
    logic [127:0] res;
    logic [4:0]   flags;
    logic         align_fault;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] P_MAX  = 64'h7FEF_FFFF_FFFF_FFFF;
    localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] D_NAN  = 64'hFFF8_0000_0000_0000;
    localparam logic [63:0] ONE    = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] M_ONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] TINY   = 64'h3C30_0000_0000_0000;
    localparam logic [63:0] M_TINY = 64'hBC30_0000_0000_0000;

    always #2 clk = ~clk;

    hpd_adder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_a(op_a), .op_b(op_b), .src_mem(src_mem), .addr_lo(addr_lo),
        .rmode(rmode), .out_valid(out_valid), .res(res), .flags(flags),
        .align_fault(align_fault)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [127:0] r_res;
    logic [4:0]   r_flg;
    logic         r_flt;
    int           r_lat;
    logic         r_held;

    task automatic run_op(input logic [127:0] a, input logic [127:0] b,
                          input logic mem, input logic [3:0] adr, input logic [1:0] rm);
        logic [127:0] prev;
        prev = res;
        in_valid = 1'b1; op_a = a; op_b = b; src_mem = mem; addr_lo = adr; rmode = rm;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        r_lat = 1;
        r_held = 1'b1;
        while (!out_valid && r_lat < 20) begin
            if (res !== prev) r_held = 1'b0;
            @(negedge clk);
            r_lat++;
        end
        r_res = res; r_flg = flags; r_flt = align_fault;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11 in_ready", 128'(in_ready), 128'd1);
        chk("R11 out_valid", 128'(out_valid), 128'd0);
        chk("R11 res", res, '0);
        chk("R11 flags", 128'(flags), '0);
        chk("R11 align_fault", 128'(align_fault), '0);
    endtask

    task automatic t_basic;
        logic [63:0] el, eh;
        el = $realtobits(1.5 + 2.25);
        eh = $realtobits(10.0 + -4.0);
        run_op({$realtobits(2.25), $realtobits(1.5)}, {$realtobits(-4.0), $realtobits(10.0)}, 1'b0, 4'd0, 2'd0);
        chk("R1 low lane exact", 128'(r_res[63:0]), 128'(el));
        chk("R2 high lane exact", 128'(r_res[127:64]), 128'(eh));
        chk("R4 exact no flags", 128'(r_flg), '0);
        chk("R10 latency", 128'(r_lat), 128'd3);
        chk("R10 result held while busy", 128'(r_held), 128'd1);
        el = $realtobits(0.1 + 0.2);
        eh = $realtobits(1.0e300 + 3.7e-5);
        run_op({$realtobits(0.2), $realtobits(0.1)}, {$realtobits(3.7e-5), $realtobits(1.0e300)}, 1'b0, 4'd0, 2'd0);
        chk("R1 low lane rounded", 128'(r_res[63:0]), 128'(el));
        chk("R2 high lane rounded", 128'(r_res[127:64]), 128'(eh));
        chk("R4 precision flag", 128'(r_flg), 128'h10);
        run_op({64'h3CA0_0000_0000_0000, ONE}, {64'h3CA0_0000_0000_0000, 64'h3FF0_0000_0000_0001}, 1'b0, 4'd0, 2'd0);
        chk("R1 tie to even down", 128'(r_res[63:0]), 128'(ONE));
        chk("R2 tie to even up", 128'(r_res[127:64]), 128'h3FF0_0000_0000_0002);
    endtask

    task automatic t_modes;
        run_op({TINY, ONE}, {M_TINY, M_ONE}, 1'b0, 4'd0, 2'd2);
        chk("R3 toward +inf positive", 128'(r_res[63:0]), 128'h3FF0_0000_0000_0001);
        chk("R3 toward +inf negative", 128'(r_res[127:64]), 128'(M_ONE));
        chk("R3 precision", 128'(r_flg), 128'h10);
        run_op({TINY, ONE}, {M_TINY, M_ONE}, 1'b0, 4'd0, 2'd1);
        chk("R3 toward -inf positive", 128'(r_res[63:0]), 128'(ONE));
        chk("R3 toward -inf negative", 128'(r_res[127:64]), 128'hBFF0_0000_0000_0001);
        run_op({TINY, ONE}, {TINY, 64'h3FFF_FFFF_FFFF_FFFF}, 1'b0, 4'd0, 2'd3);
        chk("R3 toward zero", 128'(r_res[63:0]), 128'(ONE));
        chk("R3 toward zero no carry", 128'(r_res[127:64]), 128'h3FFF_FFFF_FFFF_FFFF);
        run_op({TINY, ONE}, {TINY, 64'h3FFF_FFFF_FFFF_FFFF}, 1'b0, 4'd0, 2'd2);
        chk("R3 rounding carry into exponent", 128'(r_res[127:64]), 128'h4000_0000_0000_0000);
    endtask

    task automatic t_cancel;
        run_op({M_ONE, ONE}, {ONE, M_ONE}, 1'b0, 4'd0, 2'd0);
        chk("R7 zero nearest", r_res, '0);
        chk("R7 no flags", 128'(r_flg), '0);
        run_op({M_ONE, ONE}, {ONE, M_ONE}, 1'b0, 4'd0, 2'd1);
        chk("R7 zero toward -inf", r_res, {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000});
    endtask

    task automatic t_overflow;
        run_op({P_MAX, P_MAX}, {P_MAX | 64'h8000_0000_0000_0000, P_MAX | 64'h8000_0000_0000_0000}, 1'b0, 4'd0, 2'd0);
        chk("R5 overflow to +inf", 128'(r_res[63:0]), 128'(P_INF));
        chk("R5 overflow to -inf", 128'(r_res[127:64]), 128'(N_INF));
        chk("R5 overflow flags", 128'(r_flg), 128'h14);
        run_op({P_MAX, P_MAX}, {P_MAX | 64'h8000_0000_0000_0000, P_MAX | 64'h8000_0000_0000_0000}, 1'b0, 4'd0, 2'd3);
        chk("R5 toward zero gives max", r_res, {P_MAX | 64'h8000_0000_0000_0000, P_MAX});
        run_op({P_MAX, P_MAX}, {P_MAX | 64'h8000_0000_0000_0000, P_MAX | 64'h8000_0000_0000_0000}, 1'b0, 4'd0, 2'd2);
        chk("R5 toward +inf mixed", r_res, {P_MAX | 64'h8000_0000_0000_0000, P_INF});
    endtask

    task automatic t_nan;
        run_op({N_INF, P_INF}, {$realtobits(2.0), 64'h7FF0_0000_0000_0001}, 1'b0, 4'd0, 2'd0);
        chk("R6 inf minus inf", 128'(r_res[63:0]), 128'(D_NAN));
        chk("R6 signalling NaN", 128'(r_res[127:64]), 128'(D_NAN));
        chk("R6 invalid flag", 128'(r_flg), 128'h01);
        run_op({64'h7FF8_0000_0000_0123, ONE}, {ONE, 64'h7FF8_0000_0000_00AB}, 1'b0, 4'd0, 2'd0);
        chk("R6 quiet NaN propagates", r_res, {64'h7FF8_0000_0000_00AB, 64'h7FF8_0000_0000_0123});
        chk("R6 quiet NaN no flag", 128'(r_flg), '0);
        run_op({P_INF, P_INF}, {ONE, N_INF}, 1'b0, 4'd0, 2'd0);
        chk("R6 like infinities", r_res, {N_INF, P_INF});
    endtask

    task automatic t_merge;
        run_op({P_MAX, P_MAX}, {N_INF, P_INF}, 1'b0, 4'd0, 2'd0);
        chk("R4 lane flags ORed", 128'(r_flg), 128'h15);
        chk("R4 merged result", r_res, {D_NAN, P_INF});
    endtask

    task automatic t_subnormal;
        run_op({64'd1, 64'd1}, {64'd1, 64'h000F_FFFF_FFFF_FFFF}, 1'b0, 4'd0, 2'd0);
        chk("R8 subnormal sum", 128'(r_res[63:0]), 128'd2);
        chk("R8 subnormal to normal", 128'(r_res[127:64]), 128'h0010_0000_0000_0000);
        chk("R8 denormal flag, underflow clear", 128'(r_flg), 128'h02);
    endtask

    task automatic t_align;
        logic [127:0] keep;
        run_op({$realtobits(2.0), ONE}, {ONE, ONE}, 1'b0, 4'd0, 2'd0);
        keep = r_res;
        chk("R1 before fault", 128'(keep[63:0]), 128'(64'h4008_0000_0000_0000));
        run_op({P_MAX, P_MAX}, {ONE, ONE}, 1'b1, 4'd4, 2'd0);
        chk("R9 fault raised", 128'(r_flt), 128'd1);
        chk("R9 result kept", r_res, keep);
        chk("R9 flags zero", 128'(r_flg), '0);
        chk("R9 fault latency", 128'(r_lat), 128'd1);
        run_op({ONE, ONE}, {$realtobits(3.0), ONE}, 1'b0, 4'd4, 2'd0);
        chk("R9 register source ignores address", 128'(r_flt), 128'd0);
        chk("R2 after register source", 128'(r_res[127:64]), 128'(64'h4010_0000_0000_0000));
        run_op({ONE, ONE}, {ONE, ONE}, 1'b1, 4'd0, 2'd0);
        chk("R9 aligned memory source", 128'(r_flt), 128'd0);
        chk("R10 aligned latency", 128'(r_lat), 128'd3);
        chk("R2 aligned memory result", r_res, {64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000});
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_modes();
        t_cancel();
        t_overflow();
        t_nan();
        t_merge();
        t_subnormal();
        t_align();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule